// File: doc/BRIEF.md
# Coprocessor Error Interrupt Controller

This block closes the loop between a floating-point unit that reports an error and the interrupt logic that services it. The processor drives an active-low error pin. While the block is enabled and that pin is low, the block raises a level interrupt request on line 13. The service routine then writes to the I/O clear port at address 0x00F0. That write drops the request and pulls the active-low ignore-error output low, so the processor can carry on past the faulting instruction. The ignore output is held only while the error pin stays low. Once the processor releases the error, the block returns to idle, and a later error raises the request again.

The error pin is asynchronous. It passes through a two-flop synchronizer before the handshake state machine sees it. I/O writes arrive as a single-cycle strobe carrying a 16-bit address and 8 bits of data. The strobe acts as a valid signal with no ready: the block accepts every write on the cycle it is presented and never applies back-pressure. Only the address is decoded. One enable input gates the whole function.

Top module: `cperr_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, `irq13` is 0 and `ignore_err_n` is 1.
- R2: With `copro_en` = 1 and the block idle, `fpu_err_n` going low makes `irq13` equal 1 after the third rising clock edge, and not earlier.
- R3: A write strobe to address 0x00F0 while the request is pending makes `irq13` 0 and `ignore_err_n` 0 after the edge that samples the strobe, whatever the data byte.
- R4: A write strobe to any address other than 0x00F0 changes neither output.
- R5: Once asserted, `ignore_err_n` stays 0 for as long as `fpu_err_n` stays low.
- R6: `ignore_err_n` is only ever 0 while the synchronized error is active. It returns to 1 after the third rising edge following `fpu_err_n` going high.
- R7: A write to 0x00F0 while no request is pending leaves `irq13` at 0 and `ignore_err_n` at 1.
- R8: After the ignore output has released, a new low level on `fpu_err_n` raises `irq13` again, with the R2 latency.
- R9: With `copro_en` = 0, both outputs go inactive on the next edge. While the enable stays clear, neither the error pin nor the clear-port write activates an output. Setting the enable again while the error is still low raises `irq13` on the next edge.
- R10: If `fpu_err_n` goes high while the request is pending and no write has occurred, `irq13` returns to 0 after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| copro_en | input | 1 | Function enable; 0 disables the request and the ignore output |
| fpu_err_n | input | 1 | Asynchronous active-low error from the processor |
| io_wr_valid | input | 1 | Single-cycle I/O write strobe, always accepted |
| io_wr_addr | input | 16 | I/O write address |
| io_wr_data | input | 8 | I/O write data, not decoded |
| irq13 | output | 1 | Active-high level interrupt request on line 13 |
| ignore_err_n | output | 1 | Active-low ignore-error output to the processor |

## Verification
The assertions assume three things about the inputs:
- Every value the state machine acts on has already passed through the synchronizer.
- The write strobe never lasts longer than the cycle the interface defines.
- The enable is a quasi-static level that is sampled on the clock.

The stimulus respects these assumptions. It changes every input on the falling edge. Each write strobe is held for exactly one cycle. Any change on the error pin is held for at least three rising edges before the next change, so the state machine always observes the level it was given.

// File: rtl/cperr_pkg.sv
package cperr_pkg;
  localparam int unsigned IO_ADDR_W = 16;
  localparam int unsigned IO_DATA_W = 8;
  localparam logic [IO_ADDR_W-1:0] CLEAR_PORT = 16'h00F0;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_PEND   = 2'd1,
    HS_IGNORE = 2'd2
  } hs_state_e;
endpackage

// File: rtl/cperr_sync.sv
module cperr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end

      // R2
      sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[LAST] == $past(chain_q[LAST-1]));
    end
  endgenerate

  assign q_sync = chain_q[LAST];
endmodule

// File: rtl/cperr_port_decode.sv
module cperr_port_decode #(
  parameter int unsigned          ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]    MATCH_ADDR = 16'h00F0
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              clr_hit
);
  assign clr_hit = wr_valid && (wr_addr == MATCH_ADDR);
endmodule

// File: rtl/cperr_handshake.sv
module cperr_handshake
  import cperr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic err_act,
  input  logic clr_hit,
  output logic irq_req,
  output logic ignore_n
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = HS_IDLE;
    end else begin
      unique case (state_q)
        HS_IDLE:   if (err_act) state_d = HS_PEND;
        HS_PEND: begin
          if (!err_act)     state_d = HS_IDLE;
          else if (clr_hit) state_d = HS_IGNORE;
        end
        HS_IGNORE: if (!err_act) state_d = HS_IDLE;
        default:   state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign irq_req  = (state_q == HS_PEND);
  assign ignore_n = (state_q != HS_IGNORE);

  // R6
  ignore_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ignore_n |-> $past(err_act));

  // R9
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (irq_req == 1'b0 && ignore_n == 1'b1));

  // R3
  clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && irq_req && err_act && clr_hit) |=> (!irq_req && !ignore_n));

  // R7
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && ignore_n) |=> ignore_n);

  // R2
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && err_act && !irq_req && ignore_n) |=> irq_req);

  // R5
  hold_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ignore_n && enable && err_act) |=> !ignore_n);
endmodule

// File: rtl/cperr_irq_ctrl.sv
module cperr_irq_ctrl
  import cperr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 copro_en,
  input  logic                 fpu_err_n,
  input  logic                 io_wr_valid,
  input  logic [IO_ADDR_W-1:0] io_wr_addr,
  input  logic [IO_DATA_W-1:0] io_wr_data,
  output logic                 irq13,
  output logic                 ignore_err_n
);
  logic err_n_sync;
  logic clr_hit;
  logic unused_wr_data;

  assign unused_wr_data = ^io_wr_data;

  cperr_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (fpu_err_n),
    .q_sync  (err_n_sync)
  );

  cperr_port_decode #(
    .ADDR_W     (IO_ADDR_W),
    .MATCH_ADDR (CLEAR_PORT)
  ) u_decode (
    .wr_valid (io_wr_valid),
    .wr_addr  (io_wr_addr),
    .clr_hit  (clr_hit)
  );

  cperr_handshake u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (copro_en),
    .err_act  (!err_n_sync),
    .clr_hit  (clr_hit),
    .irq_req  (irq13),
    .ignore_n (ignore_err_n)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (!irq13 && ignore_err_n)));
endmodule

// File: tb/cperr_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cperr_irq_ctrl_tb_top;
  typedef struct {
    bit    irq;
    bit    ign_n;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        copro_en = 1'b0;
  logic        fpu_err_n = 1'b1;
  logic        io_wr_valid = 1'b0;
  logic [15:0] io_wr_addr = '0;
  logic [7:0]  io_wr_data = '0;
  logic        irq13;
  logic        ignore_err_n;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  event chk_ev;

  always #2 clk = ~clk;

  cperr_irq_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .copro_en     (copro_en),
    .fpu_err_n    (fpu_err_n),
    .io_wr_valid  (io_wr_valid),
    .io_wr_addr   (io_wr_addr),
    .io_wr_data   (io_wr_data),
    .irq13        (irq13),
    .ignore_err_n (ignore_err_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input bit irq, input bit ign_n, input string req);
    exp_t e;
    e.irq = irq; e.ign_n = ign_n; e.req = req;
    exp_q.push_back(e);
    ->chk_ev;
    #0.1;
  endtask

  task automatic io_write(input logic [15:0] addr, input logic [7:0] data);
    io_wr_valid = 1'b1; io_wr_addr = addr; io_wr_data = data;
    tick(1);
    io_wr_valid = 1'b0; io_wr_addr = '0; io_wr_data = '0;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (irq13 !== e.irq || ignore_err_n !== e.ign_n) begin
          n_bad++;
          $display("FAIL %s: irq13/ignore_err_n = %b/%b, expected %b/%b",
                   e.req, irq13, ignore_err_n, e.irq, e.ign_n);
        end
      end
    end
  end

  initial begin
    tick(3);
    expect_out(1'b0, 1'b1, "R1");
    rst_n = 1'b1;
    copro_en = 1'b1;
    tick(2);
    expect_out(1'b0, 1'b1, "R1");

    fpu_err_n = 1'b0;
    tick(2);
    expect_out(1'b0, 1'b1, "R2");
    tick(1);
    expect_out(1'b1, 1'b1, "R2");

    io_write(16'h00F1, 8'h01);
    expect_out(1'b1, 1'b1, "R4");
    io_write(16'h01F0, 8'h01);
    expect_out(1'b1, 1'b1, "R4");

    io_write(16'h00F0, 8'h5A);
    expect_out(1'b0, 1'b0, "R3");
    tick(5);
    expect_out(1'b0, 1'b0, "R5");

    fpu_err_n = 1'b1;
    tick(2);
    expect_out(1'b0, 1'b0, "R6");
    tick(1);
    expect_out(1'b0, 1'b1, "R6");

    io_write(16'h00F0, 8'hFF);
    expect_out(1'b0, 1'b1, "R7");
    tick(3);
    expect_out(1'b0, 1'b1, "R7");

    fpu_err_n = 1'b0;
    tick(3);
    expect_out(1'b1, 1'b1, "R8");

    fpu_err_n = 1'b1;
    tick(2);
    expect_out(1'b1, 1'b1, "R10");
    tick(1);
    expect_out(1'b0, 1'b1, "R10");

    fpu_err_n = 1'b0;
    tick(3);
    expect_out(1'b1, 1'b1, "R8");
    io_write(16'h00F0, 8'h00);
    expect_out(1'b0, 1'b0, "R3");
    copro_en = 1'b0;
    tick(1);
    expect_out(1'b0, 1'b1, "R9");
    tick(4);
    expect_out(1'b0, 1'b1, "R9");
    io_write(16'h00F0, 8'h00);
    expect_out(1'b0, 1'b1, "R9");
    copro_en = 1'b1;
    tick(1);
    expect_out(1'b1, 1'b1, "R9");

    fpu_err_n = 1'b1;
    tick(3);
    expect_out(1'b0, 1'b1, "R10");
    copro_en = 1'b0;
    fpu_err_n = 1'b0;
    tick(5);
    expect_out(1'b0, 1'b1, "R9");

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule